// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

A bank of general-purpose pins, one bit per pin in every register, reached through a plain register bus. The bus has single-cycle write and read strobes, a byte address and a data word as wide as the bank. Each pin has a direction bit, an output value, a rising-edge enable and a falling-edge enable. An edge that is enabled latches a sticky status bit. Software clears that bit by writing a one to it. A mask register decides which status bits reach the single level interrupt output.

Pin inputs are synchronised before they are used. An edge is found by comparing the synchronised level with its value one clock earlier. The output value can only be changed through write-only set and clear ports. Direction and both edge enables can be written directly, or changed one bit at a time through write-only set and clear aliases, so software needs no read-modify-write sequence. The direction and output vectors leave the block for the pad logic, which lives elsewhere.

The register offsets are fixed, with word spacing. The read/write registers are: direction 0x04, rising enable 0x10, falling enable 0x14, interrupt mask 0x34 and spare mask 0x38. The level register at 0x00 is read-only. The edge status register at 0x18 is write-one-to-clear. Output set is at 0x08 and output clear at 0x0C. The direction aliases are at 0x1C (set) and 0x20 (clear). The rising-enable aliases are at 0x24 (set) and 0x28 (clear). The falling-enable aliases are at 0x2C (set) and 0x30 (clear).

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous reset every readable register reads zero, and `irq`, `out_en` and `out_val` are all zero.
- R2: A read of offset 0x00 returns every pin's level after a two-flop synchroniser. A change on `pin_i` shows on the second clock after it, whatever the pin's direction.
- R3: Writing a one to a bit at 0x08 sets that bit of `out_val`, and writing a one at 0x0C clears it. Zero bits leave the output unchanged, and both offsets read back as zero.
- R4: Offset 0x04 holds direction: 1 makes the pin an output. It reads back as written and drives `out_en`.
- R5: The set aliases OR the written ones into direction (0x1C), rising enable (0x24) and falling enable (0x2C). The clear aliases remove the written ones from the same three registers (0x20, 0x28, 0x30). Every alias reads back as zero.
- R6: A rising edge on a pin whose rising enable (0x10) is 1 sets that pin's status bit at 0x18. A falling edge on that pin alone does not.
- R7: A falling edge on a pin whose falling enable (0x14) is 1 sets that pin's status bit.
- R8: A status bit stays set until software writes a 1 to that bit at 0x18. Zero bits in the write leave the other status bits unchanged.
- R9: `irq` is high exactly while some status bit and the same mask bit (0x34, 1 enables) are both 1. A masked edge is still latched in status.
- R10: When a qualifying edge and a clear of the same status bit fall in one cycle, the bit stays set.
- R11: Offset 0x3C, offsets above it and misaligned offsets read zero, and writes to them change nothing.
- R12: The spare mask at 0x38 reads back as written and has no effect on `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read strobe; `rdata` is valid in the same cycle |
| addr | input | AW (8) | Byte address |
| wdata | input | N (32) | Write data |
| rdata | output | N (32) | Read data, zero when `rd_en` is low |
| pin_i | input | N (32) | Asynchronous pin levels from the pads |
| out_en | output | N (32) | Per-pin output enable (direction) |
| out_val | output | N (32) | Per-pin output value |
| irq | output | 1 | Level interrupt |

## Verification
Directed patterns come first, one per concern. A level step read on both sides of the synchroniser latency separates a one-stage synchroniser from a two-stage one. Single-pin rising and falling steps with only one enable set show whether the two edge directions are kept apart. A clear that lands in the very cycle of a new edge decides the priority between the edge and the clear. Random traffic then mixes writes to every offset, including unmapped and misaligned ones, with sparse pin toggles. This shows up cross-talk between the alias ports and their target registers, and any W1C behaviour that touches bits which were not written.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the GPIO bank: register word indices and the
// one-hot write strobe bundle passed from the decoder to the register file.
package gpio_bank_pkg;

    localparam int IDX_W   = 4;   // word index bits in the address
    localparam int IDX_LSB = 2;   // word spacing of four bytes

    typedef enum logic [IDX_W-1:0] {
        IDX_LEVEL = 4'd0,
        IDX_DIR   = 4'd1,
        IDX_OSET  = 4'd2,
        IDX_OCLR  = 4'd3,
        IDX_RISE  = 4'd4,
        IDX_FALL  = 4'd5,
        IDX_STAT  = 4'd6,
        IDX_DSET  = 4'd7,
        IDX_DCLR  = 4'd8,
        IDX_RSET  = 4'd9,
        IDX_RCLR  = 4'd10,
        IDX_FSET  = 4'd11,
        IDX_FCLR  = 4'd12,
        IDX_MASK  = 4'd13,
        IDX_MASK2 = 4'd14,
        IDX_NONE  = 4'd15
    } reg_idx_e;

    typedef struct packed {
        logic dir_wr;
        logic dir_set;
        logic dir_clr;
        logic out_set;
        logic out_clr;
        logic rise_wr;
        logic rise_set;
        logic rise_clr;
        logic fall_wr;
        logic fall_set;
        logic fall_clr;
        logic mask_wr;
        logic mask2_wr;
        logic stat_w1c;
    } wr_strobe_t;

endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
// Input conditioning: a STAGES-deep synchroniser per pin, a one-cycle
// history register, and per-pin rising/falling edge pulses.
// Assumes pins are asynchronous and glitch-free across one clock period.
module gpio_in_sync #(
    parameter int N      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    logic [STAGES-1:0][N-1:0] stage_q;
    logic [N-1:0]             prev_q;

    // Shift pin levels through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= pin_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    // Remember the synchronised level for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level_o;
    end

    assign level_o = stage_q[STAGES-1];
    assign rise_o  = level_o & ~prev_q;
    assign fall_o  = ~level_o & prev_q;

endmodule

// File: rtl/gpio_ctrl_regs.sv
`timescale 1ns/1ps
// Control register file: direction, output value, rising and falling
// enables, interrupt mask and spare mask. Direction and the enables take
// direct writes and set/clear alias writes; the output value takes only
// set/clear writes. Assumes at most one strobe is active per cycle.
module gpio_ctrl_regs
    import gpio_bank_pkg::*;
#(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  wr_strobe_t   strb,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] dir_q,
    output logic [N-1:0] out_q,
    output logic [N-1:0] rise_q,
    output logic [N-1:0] fall_q,
    output logic [N-1:0] mask_q,
    output logic [N-1:0] mask2_q
);

    // Next value of a register with direct, OR-in and AND-out writes.
    function automatic logic [N-1:0] upd(
        input logic [N-1:0] cur,
        input logic [N-1:0] d,
        input logic         wr,
        input logic         set,
        input logic         clr
    );
        logic [N-1:0] r;
        r = cur;
        if (wr)  r = d;
        if (set) r = r | d;
        if (clr) r = r & ~d;
        return r;
    endfunction

    // Update the three aliased registers and the output value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            dir_q  <= upd(dir_q,  wdata, strb.dir_wr,  strb.dir_set,  strb.dir_clr);
            out_q  <= upd(out_q,  wdata, 1'b0,         strb.out_set,  strb.out_clr);
            rise_q <= upd(rise_q, wdata, strb.rise_wr, strb.rise_set, strb.rise_clr);
            fall_q <= upd(fall_q, wdata, strb.fall_wr, strb.fall_set, strb.fall_clr);
        end
    end

    // Update the two plain mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            mask2_q <= '0;
        end else begin
            if (strb.mask_wr)  mask_q  <= wdata;
            if (strb.mask2_wr) mask2_q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_edge_status.sv
`timescale 1ns/1ps
// Sticky edge status with write-one-to-clear, and the masked interrupt.
// A qualifying edge in the same cycle as a clear of that bit wins.
module gpio_edge_status #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] rise_evt,
    input  logic [N-1:0] fall_evt,
    input  logic [N-1:0] rise_en,
    input  logic [N-1:0] fall_en,
    input  logic         w1c,
    input  logic [N-1:0] wdata,
    input  logic [N-1:0] mask,
    output logic [N-1:0] status_q,
    output logic         irq_o
);

    logic [N-1:0] hit;
    logic [N-1:0] clr;

    // Qualify edges with their enables and form the clear vector.
    always_comb begin
        hit = (rise_evt & rise_en) | (fall_evt & fall_en);
        clr = w1c ? wdata : '0;
    end

    // Latch status; new hits override a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr) | hit;
    end

    assign irq_o = |(status_q & mask);

endmodule

// File: rtl/gpio_edge_bank.sv
`timescale 1ns/1ps
// GPIO bank top: address decode, read mux, and the three sub-blocks.
// Assumes AW >= 7 and a data bus N bits wide; rdata is combinational
// and is valid in the same cycle as rd_en.
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int N       = 32,
    parameter int AW      = 8,
    parameter int STAGES  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [N-1:0]  wdata,
    output logic [N-1:0]  rdata,
    input  logic [N-1:0]  pin_i,
    output logic [N-1:0]  out_en,
    output logic [N-1:0]  out_val,
    output logic          irq
);

    localparam int HI_LSB = IDX_LSB + IDX_W;

    logic [IDX_W-1:0] idx;
    logic             mapped;
    reg_idx_e         sel;
    wr_strobe_t       strb;

    logic [N-1:0] level, rise_evt, fall_evt;
    logic [N-1:0] dir_q, out_q, rise_q, fall_q, mask_q, mask2_q;
    logic [N-1:0] status_q;
    logic [N-1:0] rd_mux;

    // Decide whether the address names a register and which one.
    always_comb begin
        idx    = addr[HI_LSB-1:IDX_LSB];
        mapped = (addr[IDX_LSB-1:0] == '0) && (addr[AW-1:HI_LSB] == '0)
                 && (idx != IDX_NONE);
        sel    = mapped ? reg_idx_e'(idx) : IDX_NONE;
    end

    // Turn a bus write into one register strobe.
    always_comb begin
        strb = '0;
        if (wr_en) begin
            unique case (sel)
                IDX_DIR:   strb.dir_wr   = 1'b1;
                IDX_OSET:  strb.out_set  = 1'b1;
                IDX_OCLR:  strb.out_clr  = 1'b1;
                IDX_RISE:  strb.rise_wr  = 1'b1;
                IDX_FALL:  strb.fall_wr  = 1'b1;
                IDX_STAT:  strb.stat_w1c = 1'b1;
                IDX_DSET:  strb.dir_set  = 1'b1;
                IDX_DCLR:  strb.dir_clr  = 1'b1;
                IDX_RSET:  strb.rise_set = 1'b1;
                IDX_RCLR:  strb.rise_clr = 1'b1;
                IDX_FSET:  strb.fall_set = 1'b1;
                IDX_FCLR:  strb.fall_clr = 1'b1;
                IDX_MASK:  strb.mask_wr  = 1'b1;
                IDX_MASK2: strb.mask2_wr = 1'b1;
                default:   strb = '0;
            endcase
        end
    end

    // Select read data; write-only and unmapped offsets give zero.
    always_comb begin
        unique case (sel)
            IDX_LEVEL: rd_mux = level;
            IDX_DIR:   rd_mux = dir_q;
            IDX_RISE:  rd_mux = rise_q;
            IDX_FALL:  rd_mux = fall_q;
            IDX_STAT:  rd_mux = status_q;
            IDX_MASK:  rd_mux = mask_q;
            IDX_MASK2: rd_mux = mask2_q;
            default:   rd_mux = '0;
        endcase
        rdata = rd_en ? rd_mux : '0;
    end

    gpio_in_sync #(.N(N), .STAGES(STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (level),
        .rise_o  (rise_evt),
        .fall_o  (fall_evt)
    );

    gpio_ctrl_regs #(.N(N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb    (strb),
        .wdata   (wdata),
        .dir_q   (dir_q),
        .out_q   (out_q),
        .rise_q  (rise_q),
        .fall_q  (fall_q),
        .mask_q  (mask_q),
        .mask2_q (mask2_q)
    );

    gpio_edge_status #(.N(N)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt),
        .rise_en  (rise_q),
        .fall_en  (fall_q),
        .w1c      (strb.stat_w1c),
        .wdata    (wdata),
        .mask     (mask_q),
        .status_q (status_q),
        .irq_o    (irq)
    );

    assign out_en  = dir_q;
    assign out_val = out_q;

endmodule

// File: rtl/gpio_edge_bank_chk.sv
`timescale 1ns/1ps
// Property checker for gpio_edge_bank, attached by bind. It watches the
// bus ports, the outputs and the register and status state.
module gpio_edge_bank_chk #(
    parameter int N  = 32,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic [N-1:0]  wdata,
    input logic [N-1:0]  rdata,
    input logic [N-1:0]  out_en,
    input logic [N-1:0]  out_val,
    input logic          irq,
    input logic [N-1:0]  status_q,
    input logic [N-1:0]  mask_q,
    input logic [N-1:0]  rise_q,
    input logic [N-1:0]  fall_q
);

    localparam logic [AW-1:0] OSET_ADDR = AW'(8'h08);
    localparam logic [AW-1:0] STAT_ADDR = AW'(8'h18);
    localparam logic [AW-1:0] TOP_ADDR  = AW'(8'h3C);

    logic unmapped;
    assign unmapped = (addr[1:0] != 2'b00) || (addr >= TOP_ADDR);

    // R1: reset leaves status, interrupt and output enables cleared
    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && !irq && out_en == '0));

    // R3: a set-port write drives all written ones high
    a_r3_set_drives_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OSET_ADDR) |=> ((out_val & $past(wdata)) == $past(wdata)));

    // R6, R7: a new status bit appears only on a pin with an edge enable
    a_r6_new_bit_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(rise_q | fall_q)) == '0));

    // R8: status bits fall only after a write to the status offset
    a_r8_sticky_status: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == STAT_ADDR) |=> (($past(status_q) & ~status_q) == '0));

    // R9: no interrupt without both a pending bit and a mask bit
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0 || status_q == '0) |-> !irq);

    // R11: unmapped offsets read as zero
    a_r11_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |-> (rdata == '0));

endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.N(N), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .out_en   (out_en),
    .out_val  (out_val),
    .irq      (irq),
    .status_q (status_q),
    .mask_q   (mask_q),
    .rise_q   (rise_q),
    .fall_q   (fall_q)
);

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns/1ps
module gpio_edge_bank_bench;

    localparam int N  = 32;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  pin_i = '0;
    logic [N-1:0]  rdata, out_en, out_val;
    logic          irq;

    gpio_edge_bank #(.N(N), .AW(AW)) u_gpio_edge_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pin_i(pin_i),
        .out_en(out_en), .out_val(out_val), .irq(irq)
    );

    always #10 clk = ~clk;   // 50 MHz

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    logic [N-1:0] m_dir = '0, m_out = '0, m_rise = '0, m_fall = '0;
    logic [N-1:0] m_mask = '0, m_mask2 = '0, m_stat = '0, m_pins = '0;

    task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic bit is_unmapped(input logic [AW-1:0] a);
        return (a[1:0] != 2'b00) || (a >= 8'h3C);
    endfunction

    function automatic logic [N-1:0] exp_read(input logic [AW-1:0] a);
        if (is_unmapped(a)) return '0;
        case (a[5:2])
            4'd0:  return m_pins;
            4'd1:  return m_dir;
            4'd4:  return m_rise;
            4'd5:  return m_fall;
            4'd6:  return m_stat;
            4'd13: return m_mask;
            4'd14: return m_mask2;
            default: return '0;
        endcase
    endfunction

    task automatic model_write(input logic [AW-1:0] a, input logic [N-1:0] d);
        if (is_unmapped(a)) return;
        case (a[5:2])
            4'd1:  m_dir   = d;
            4'd2:  m_out   = m_out | d;
            4'd3:  m_out   = m_out & ~d;
            4'd4:  m_rise  = d;
            4'd5:  m_fall  = d;
            4'd6:  m_stat  = m_stat & ~d;
            4'd7:  m_dir   = m_dir | d;
            4'd8:  m_dir   = m_dir & ~d;
            4'd9:  m_rise  = m_rise | d;
            4'd10: m_rise  = m_rise & ~d;
            4'd11: m_fall  = m_fall | d;
            4'd12: m_fall  = m_fall & ~d;
            4'd13: m_mask  = d;
            4'd14: m_mask2 = d;
            default: ;
        endcase
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic read_check(input string req, input logic [AW-1:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        check(req, rdata, exp_read(a));
        rd_en = 1'b0;
    endtask

    task automatic drive_pins(input logic [N-1:0] v);
        m_stat = m_stat | (v & ~m_pins & m_rise) | (~v & m_pins & m_fall);
        @(negedge clk);
        pin_i  = v;
        m_pins = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic check_ports(input string req);
        check({req, " irq"},     {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_stat & m_mask)});
        check({req, " out_en"},  out_en,  m_dir);
        check({req, " out_val"}, out_val, m_out);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(64'd20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every offset zero after reset
        for (int i = 0; i < 16; i++) read_check("R1 reset read", AW'(i * 4));
        check_ports("R1 reset ports");

        // R2: level latency of two clocks, independent of direction
        bus_write(8'h04, 32'h0000_00F0);
        @(negedge clk); pin_i = 32'hA5A5_0FF0;
        @(negedge clk); rd_en = 1'b1; addr = 8'h00; #1;
        check("R2 level before sync", rdata, 32'h0);
        rd_en = 1'b0;
        @(negedge clk); rd_en = 1'b1; addr = 8'h00; #1;
        check("R2 level after sync", rdata, 32'hA5A5_0FF0);
        rd_en = 1'b0;
        m_pins = 32'hA5A5_0FF0;
        repeat (2) @(negedge clk);

        // R3: output set and clear ports
        bus_write(8'h08, 32'h8000_0011);
        check("R3 set ones", out_val, 32'h8000_0011);
        bus_write(8'h0C, 32'h0000_0010);
        check("R3 clear one", out_val, 32'h8000_0001);
        read_check("R3 set port reads zero", 8'h08);
        read_check("R3 clear port reads zero", 8'h0C);

        // R4: direct direction write
        bus_write(8'h04, 32'h1234_5678);
        read_check("R4 direction readback", 8'h04);
        check("R4 out_en", out_en, 32'h1234_5678);

        // R5: alias set/clear on the three registers
        bus_write(8'h1C, 32'h0000_0F00);
        bus_write(8'h20, 32'h1000_0008);
        read_check("R5 direction after aliases", 8'h04);
        check("R5 direction value", out_en, 32'h0234_5F70);
        bus_write(8'h24, 32'h0000_0003);
        bus_write(8'h28, 32'h0000_0001);
        bus_write(8'h2C, 32'h0000_000C);
        bus_write(8'h30, 32'h0000_0004);
        read_check("R5 rising enable", 8'h10);
        read_check("R5 falling enable", 8'h14);
        read_check("R5 alias reads zero", 8'h24);
        read_check("R5 alias reads zero", 8'h30);

        // start edge tests from a quiet state
        bus_write(8'h10, 32'h0);
        bus_write(8'h14, 32'h0);
        drive_pins(32'h0);
        bus_write(8'h18, 32'hFFFF_FFFF);

        // R6: rising enabled only on bit 5
        bus_write(8'h10, 32'h0000_0020);
        drive_pins(32'h0000_0020);
        read_check("R6 rising edge latched", 8'h18);
        check("R6 status bit5", m_stat, 32'h0000_0020);
        bus_write(8'h18, 32'h0000_0020);
        drive_pins(32'h0);
        read_check("R6 falling ignored by rise enable", 8'h18);

        // R7: falling enabled on bit 9
        bus_write(8'h14, 32'h0000_0200);
        drive_pins(32'h0000_0200);
        read_check("R7 rising ignored", 8'h18);
        drive_pins(32'h0);
        read_check("R7 falling edge latched", 8'h18);

        // R8: sticky, W1C clears only written ones
        bus_write(8'h10, 32'h0000_0021);
        drive_pins(32'h0000_0021);
        read_check("R8 two bits set", 8'h18);
        bus_write(8'h18, 32'h0000_0001);
        read_check("R8 partial clear", 8'h18);
        repeat (5) @(negedge clk);
        read_check("R8 still sticky", 8'h18);

        // R9: masking
        check_ports("R9 masked off");
        bus_write(8'h34, 32'h0000_0020);
        check_ports("R9 unmasked");
        check("R9 irq high", {31'b0, irq}, 32'h1);
        bus_write(8'h34, 32'h0000_0001);
        check("R9 other mask bit", {31'b0, irq}, 32'h0);

        // R10: edge and clear in the same cycle on bit 3
        bus_write(8'h18, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'h0000_0008);
        bus_write(8'h14, 32'h0000_0008);
        bus_write(8'h34, 32'h0000_0008);
        drive_pins(32'h0000_0008);
        @(negedge clk); pin_i = 32'h0;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 8'h18; wdata = 32'h0000_0008;
        @(negedge clk); wr_en = 1'b0;
        m_pins = 32'h0;
        repeat (2) @(negedge clk);
        read_check("R10 edge beats clear", 8'h18);
        check("R10 bit kept", m_stat, 32'h0000_0008);
        check_ports("R10 irq");
        bus_write(8'h18, 32'h0000_0008);
        read_check("R10 plain clear", 8'h18);

        // R11: unmapped and misaligned offsets
        bus_write(8'h3C, 32'hFFFF_FFFF);
        bus_write(8'h84, 32'hFFFF_FFFF);
        bus_write(8'h05, 32'hFFFF_FFFF);
        read_check("R11 direction untouched", 8'h04);
        read_check("R11 read 0x3C", 8'h3C);
        read_check("R11 read 0x84", 8'h84);
        read_check("R11 read misaligned", 8'h35);

        // R12: spare mask has no effect on irq
        bus_write(8'h34, 32'h0);
        bus_write(8'h38, 32'hFFFF_FFFF);
        drive_pins(32'h0000_0008);
        read_check("R12 spare mask readback", 8'h38);
        check("R12 irq stays low", {31'b0, irq}, 32'h0);

        // random mix
        for (int it = 0; it < 3000; it++) begin
            int op;
            logic [AW-1:0] a;
            logic [N-1:0]  d;
            op = int'($urandom % 5);
            if (op < 2) begin
                if ($urandom % 16 == 0) a = AW'($urandom);
                else                    a = AW'(($urandom % 15) * 4);
                d = $urandom;
                if ($urandom % 2 == 0) d = d & $urandom & $urandom;
                bus_write(a, d);
            end else if (op == 2) begin
                drive_pins(m_pins ^ ($urandom & $urandom & $urandom));
            end else begin
                a = ($urandom % 8 == 0) ? AW'($urandom) : AW'(($urandom % 15) * 4);
                read_check("R2-R12 random read", a);
            end
            check_ports("R3 R4 R9 random ports");
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule